// File: doc/BRIEF.md
# Multi-Channel Error Event Aggregator

This block watches a parameterised bundle of error event lines, 128 by default. Each line is synchronised, and its rising edge counts as an event. The event sets a sticky status bit that stays set until software clears it or the block is reset. A status bit latches whether or not the channel has been armed. So software can always tell which lines fired, and arming a channel that already fired raises its output at once.

Each channel can be armed for interrupt delivery and routed to one of two group interrupt lines, high-level or low-level. Each group has a fixed-priority encoder: channel 0 ranks first. Software reads from it the number of the first pending channel, plus one, and reads zero when nothing in that group is pending.

A separate per-channel mask selects which channels act on the external error pin. The block exports the OR of those channels as a level request to the pin controller. It also exports a single-cycle pulse on every fresh qualifying event. Software reaches all state through a synchronous register port. Enable, level and influence each have a write-one-to-set and write-one-to-clear pair, and status is cleared by writing one to its bit.

Top module: `err_event_agg`

## Requirements
- R1: A synchronous active-high reset clears every status bit, every interrupt enable, every level selection (all channels go to the low group), every pin influence bit and all four outputs.
- R2: A rising edge on a channel input sets that channel's status bit even when its interrupt enable and pin influence are both off; arming it afterwards raises the matching output within three cycles.
- R3: Channel bank b (32 channels, channel b*32+i at bit i) occupies addresses b*8 to b*8+7. Writing 1 at offset 0 enables interrupts for that channel and writing 1 at offset 1 disables them. Reading either offset returns the enable mask.
- R4: Writing 1 at bank offset 2 routes a channel to the high-level group and writing 1 at bank offset 3 routes it to the low-level group; reading either offset returns the level mask (1 = high group).
- R5: Writing 1 at bank offset 4 sets a channel's error-pin influence and writing 1 at offset 5 clears it; reading either offset returns the mask, and influence has no effect on the interrupt outputs.
- R6: irq_high is the OR over channels with status set, interrupt enabled and routed high; irq_low is the same for channels routed low.
- R7: The offset registers at address NB*8 (high group) and NB*8+1 (low group), with NB the bank count, read the lowest-numbered pending enabled channel of that group plus one, or 0 when none is pending.
- R8: Writing 1 to a status bit at bank offset 6 clears it, but a detection on that channel in the same cycle leaves the bit set; reading offset 6 returns the status bits.
- R9: err_req is the OR over channels with status set and influence enabled; err_pulse is high for exactly one cycle for each detection on a channel whose influence is set, and never for a channel without it.
- R10: In the default edge mode a line held high produces one event only, so a status bit cleared while its input stays high does not set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NUM_CH | Raw error event lines, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears on rdata the next cycle |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Registered read data |
| irq_high | output | 1 | High-level group interrupt |
| irq_low | output | 1 | Low-level group interrupt |
| err_req | output | 1 | Aggregated error request to the pin controller |
| err_pulse | output | 1 | One-cycle pulse per new event on an influencing channel |

## Verification
The status clear and a fresh detection on the same channel can land on the same clock edge, and the detection must win. The bench starts the write-one-to-clear exactly two edges after it raises the input, so the clear lands with the output of the two-stage synchroniser, and then reads the status back to see that the bit survived. A second clear, with the input still held high, must then take effect, which shows that the first clear was not simply lost. Priority is swept over every channel against a second pending channel in the same group and against a neighbour routed to the other group.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;

  // Per-bank register selector (low three address bits).
  typedef enum logic [2:0] {
    SEL_IEN_SET = 3'd0,
    SEL_IEN_CLR = 3'd1,
    SEL_LVL_HI  = 3'd2,
    SEL_LVL_LO  = 3'd3,
    SEL_PIN_SET = 3'd4,
    SEL_PIN_CLR = 3'd5,
    SEL_STATUS  = 3'd6,
    SEL_SPARE   = 3'd7
  } bank_sel_e;

  // Selectors inside the global bank placed after the last channel bank.
  localparam logic [2:0] GSEL_OFF_HI = 3'd0;
  localparam logic [2:0] GSEL_OFF_LO = 3'd1;

endpackage

// File: rtl/err_agg_detect.sv
module err_agg_detect #(
  parameter int NUM_CH      = 128,
  parameter int SYNC_STAGES = 2,
  parameter bit EDGE_MODE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_in,
  output logic [NUM_CH-1:0] det
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_CH-1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= ev_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  generate
    if (EDGE_MODE) begin : g_edge
      logic [NUM_CH-1:0] prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sync_q[LAST];
      end
      assign det = sync_q[LAST] & ~prev_q;
    end else begin : g_level
      assign det = sync_q[LAST];
    end
  endgenerate

endmodule

// File: rtl/err_agg_prio.sv
module err_agg_prio #(
  parameter int NUM_CH = 128,
  parameter int OFF_W  = 8
) (
  input  logic [NUM_CH-1:0] req,
  output logic [OFF_W-1:0]  off
);

  // Scan from the top so the lowest index present ends up in off.
  always_comb begin
    off = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) off = OFF_W'(i + 1);
    end
  end

endmodule

// File: rtl/err_agg_regs.sv
module err_agg_regs
  import err_agg_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] det,
  input  logic [OFF_W-1:0]  off_hi,
  input  logic [OFF_W-1:0]  off_lo,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] ien,
  output logic [NUM_CH-1:0] lvl,
  output logic [NUM_CH-1:0] pin,
  output logic [NUM_CH-1:0] status
);

  localparam int NUM_BANK = NUM_CH / DATA_W;
  localparam int BIDX_W   = ADDR_W - 3;

  logic [BIDX_W-1:0] bank_idx;
  bank_sel_e         sel;

  assign bank_idx = addr[ADDR_W-1:3];
  assign sel      = bank_sel_e'(addr[2:0]);

  logic [NUM_CH-1:0] ien_set, ien_clr, lvl_set, lvl_clr, pin_set, pin_clr, st_clr;

  generate
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      logic hit;
      assign hit = wr_en && (bank_idx == BIDX_W'(b));
      assign ien_set[b*DATA_W +: DATA_W] = (hit && sel == SEL_IEN_SET) ? wdata : '0;
      assign ien_clr[b*DATA_W +: DATA_W] = (hit && sel == SEL_IEN_CLR) ? wdata : '0;
      assign lvl_set[b*DATA_W +: DATA_W] = (hit && sel == SEL_LVL_HI)  ? wdata : '0;
      assign lvl_clr[b*DATA_W +: DATA_W] = (hit && sel == SEL_LVL_LO)  ? wdata : '0;
      assign pin_set[b*DATA_W +: DATA_W] = (hit && sel == SEL_PIN_SET) ? wdata : '0;
      assign pin_clr[b*DATA_W +: DATA_W] = (hit && sel == SEL_PIN_CLR) ? wdata : '0;
      assign st_clr [b*DATA_W +: DATA_W] = (hit && sel == SEL_STATUS)  ? wdata : '0;
    end
  endgenerate

  logic [NUM_CH-1:0] ien_q, lvl_q, pin_q, status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q    <= '0;
      lvl_q    <= '0;
      pin_q    <= '0;
      status_q <= '0;
    end else begin
      ien_q    <= (ien_q | ien_set) & ~ien_clr;
      lvl_q    <= (lvl_q | lvl_set) & ~lvl_clr;
      pin_q    <= (pin_q | pin_set) & ~pin_clr;
      // A detection in the clearing cycle wins over the clear.
      status_q <= (status_q & ~st_clr) | det;
    end
  end

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    int unsigned base;
    base   = 0;
    rd_mux = '0;
    if (bank_idx < BIDX_W'(NUM_BANK)) begin
      base = int'(bank_idx) * DATA_W;
      case (sel)
        SEL_IEN_SET, SEL_IEN_CLR: rd_mux = ien_q[base +: DATA_W];
        SEL_LVL_HI,  SEL_LVL_LO:  rd_mux = lvl_q[base +: DATA_W];
        SEL_PIN_SET, SEL_PIN_CLR: rd_mux = pin_q[base +: DATA_W];
        SEL_STATUS:               rd_mux = status_q[base +: DATA_W];
        default:                  rd_mux = '0;
      endcase
    end else if (bank_idx == BIDX_W'(NUM_BANK)) begin
      if (addr[2:0] == GSEL_OFF_HI)      rd_mux = DATA_W'(off_hi);
      else if (addr[2:0] == GSEL_OFF_LO) rd_mux = DATA_W'(off_lo);
    end
  end

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata  = rdata_q;
  assign ien    = ien_q;
  assign lvl    = lvl_q;
  assign pin    = pin_q;
  assign status = status_q;

endmodule

// File: rtl/err_event_agg.sv
module err_event_agg #(
  parameter int NUM_CH      = 128,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit EDGE_MODE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_high,
  output logic              irq_low,
  output logic              err_req,
  output logic              err_pulse
);

  localparam int OFF_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] det, ien, lvl, pin, status_w;
  logic [NUM_CH-1:0] pend_hi, pend_lo;
  logic [OFF_W-1:0]  off_hi_d, off_lo_d, off_hi_q, off_lo_q;

  err_agg_detect #(
    .NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES), .EDGE_MODE(EDGE_MODE)
  ) detect_i (
    .clk(clk), .rst(rst), .ev_in(ev_in), .det(det)
  );

  err_agg_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .det(det), .off_hi(off_hi_q), .off_lo(off_lo_q),
    .rdata(rdata), .ien(ien), .lvl(lvl), .pin(pin), .status(status_w)
  );

  assign pend_hi = status_w & ien &  lvl;
  assign pend_lo = status_w & ien & ~lvl;

  err_agg_prio #(.NUM_CH(NUM_CH), .OFF_W(OFF_W)) prio_hi_i (.req(pend_hi), .off(off_hi_d));
  err_agg_prio #(.NUM_CH(NUM_CH), .OFF_W(OFF_W)) prio_lo_i (.req(pend_lo), .off(off_lo_d));

  logic irq_hi_q, irq_lo_q, err_req_q, err_pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_hi_q    <= 1'b0;
      irq_lo_q    <= 1'b0;
      err_req_q   <= 1'b0;
      err_pulse_q <= 1'b0;
      off_hi_q    <= '0;
      off_lo_q    <= '0;
    end else begin
      irq_hi_q    <= |pend_hi;
      irq_lo_q    <= |pend_lo;
      err_req_q   <= |(status_w & pin);
      err_pulse_q <= |(det & pin);
      off_hi_q    <= off_hi_d;
      off_lo_q    <= off_lo_d;
    end
  end

  assign irq_high  = irq_hi_q;
  assign irq_low   = irq_lo_q;
  assign err_req   = err_req_q;
  assign err_pulse = err_pulse_q;

endmodule

// File: rtl/err_agg_checker.sv
module err_agg_checker #(
  parameter int NUM_CH = 128,
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] status,
  input logic [OFF_W-1:0]  off_hi,
  input logic [OFF_W-1:0]  off_lo,
  input logic              irq_high,
  input logic              irq_low,
  input logic              err_req,
  input logic              err_pulse
);

  // R1: reset leaves no status and quiet outputs
  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (status == '0) && !irq_high && !irq_low && !err_req && !err_pulse);

  // R8: a status bit only drops after a write to a status register
  assert_sticky_status_R8: assert property (@(posedge clk) disable iff (rst)
    (|($past(status) & ~status)) |->
      ($past(wr_en) && $past(addr[2:0]) == 3'(err_agg_pkg::SEL_STATUS)));

  // R6 / R7: group interrupt and its offset agree
  assert_high_offset_R7: assert property (@(posedge clk) disable iff (rst)
    irq_high == (off_hi != '0));

  assert_low_offset_R7: assert property (@(posedge clk) disable iff (rst)
    irq_low == (off_lo != '0));

  // R9: a pulse is followed by a standing request unless influence was rewritten
  assert_pulse_then_req_R9: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && !$past(wr_en)) |=> err_req);

  // R7: offsets never exceed the channel count
  assert_offset_range_R7: assert property (@(posedge clk) disable iff (rst)
    (off_hi <= OFF_W'(NUM_CH)) && (off_lo <= OFF_W'(NUM_CH)));

endmodule

bind err_event_agg err_agg_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .status(status_w),
  .off_hi(off_hi_q), .off_lo(off_lo_q), .irq_high(irq_high), .irq_low(irq_low),
  .err_req(err_req), .err_pulse(err_pulse)
);

// File: tb/err_event_agg_tb_top.sv
module err_event_agg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NB = N / DW;
  localparam int A_OFF_HI = NB * 8;
  localparam int A_OFF_LO = NB * 8 + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  ev_in;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          irq_high, irq_low, err_req, err_pulse;

  int checks = 0;
  int failures = 0;
  int pulse_cnt = 0;

  err_event_agg #(.NUM_CH(N), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .ev_in(ev_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_high(irq_high),
    .irq_low(irq_low), .err_req(err_req), .err_pulse(err_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (!rst && err_pulse) pulse_cnt <= pulse_cnt + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ev(input logic [N-1:0] v);
    @(negedge clk);
    ev_in = v;
  endtask

  task automatic clear_status();
    for (int b = 0; b < NB; b++) wr(b*8 + 6, '1);
  endtask

  task automatic read_status(output logic [N-1:0] v);
    logic [DW-1:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(b*8 + 6, d);
      v[b*DW +: DW] = d;
    end
  endtask

  function automatic logic [N-1:0] bit_of(input int c);
    return N'(1) << c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [N-1:0]  st;
    int p0;
    rst = 1'b1; ev_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    settle(4);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    chk("R1 irq_high", irq_high, 0);
    chk("R1 irq_low", irq_low, 0);
    chk("R1 err_req", err_req, 0);
    read_status(st); chk("R1 status", st, 0);
    rd(0, d); chk("R1 enable mask", d, 0);
    rd(2, d); chk("R1 level mask", d, 0);
    rd(A_OFF_HI, d); chk("R1 offset high", d, 0);

    // R2: latch while unarmed, then arm
    set_ev(bit_of(5)); settle(6);
    read_status(st); chk("R2 status latched unarmed", st, bit_of(5));
    chk("R2 irq_low unarmed", irq_low, 0);
    chk("R2 err_req unarmed", err_req, 0);
    set_ev('0);
    wr(0, 32'h20); settle(3);
    chk("R2 irq_low after arming", irq_low, 1);
    rd(A_OFF_LO, d); chk("R7 low offset ch5", d, 6);
    rd(A_OFF_HI, d); chk("R7 high offset empty", d, 0);

    // R3: enable set/clear pair
    rd(0, d); chk("R3 read set reg", d, 32'h20);
    rd(1, d); chk("R3 read clear reg", d, 32'h20);
    wr(8, 32'h1); rd(9, d); chk("R3 bank1 enable", d, 1);
    wr(9, 32'h1); rd(8, d); chk("R3 bank1 disable", d, 0);
    wr(1, 32'h20); rd(0, d); chk("R3 disabled mask", d, 0);
    settle(3); chk("R3 irq_low after disable", irq_low, 0);

    // R4: level routing
    wr(2, 32'h20); wr(0, 32'h20); settle(3);
    chk("R4 irq_high routed high", irq_high, 1);
    chk("R4 irq_low routed high", irq_low, 0);
    rd(3, d); chk("R4 level mask", d, 32'h20);
    rd(A_OFF_HI, d); chk("R7 high offset ch5", d, 6);
    wr(3, 32'h20); settle(3);
    chk("R4 irq_high routed low", irq_high, 0);
    chk("R4 irq_low routed low", irq_low, 1);

    // R8: write-one-to-clear
    wr(6, 32'h20); settle(3);
    read_status(st); chk("R8 cleared", st, 0);
    chk("R8 irq_low after clear", irq_low, 0);
    set_ev(bit_of(9)); settle(6); set_ev('0); settle(4);
    read_status(st); chk("R8 ch9 latched", st, bit_of(9));
    // clear lands on the same edge as the new detection
    @(negedge clk) ev_in = bit_of(9);
    @(negedge clk);
    wr(6, 32'h200); settle(6);
    read_status(st); chk("R8 detection beats clear", st, bit_of(9));
    // R10: held input does not set again
    wr(6, 32'h200); settle(6);
    read_status(st); chk("R10 no relatch while held", st, 0);
    set_ev('0); settle(3);

    // R5 / R9: pin influence path
    wr(4, 32'h100000);
    rd(5, d); chk("R5 influence mask", d, 32'h100000);
    p0 = pulse_cnt;
    set_ev(bit_of(20)); settle(8);
    chk("R9 err_req", err_req, 1);
    chk("R9 one pulse", pulse_cnt - p0, 1);
    chk("R5 irq_high untouched", irq_high, 0);
    chk("R5 irq_low untouched", irq_low, 0);
    set_ev(bit_of(20) | bit_of(21)); settle(8);
    chk("R9 no pulse without influence", pulse_cnt - p0, 1);
    read_status(st); chk("R9 status both", st, bit_of(20) | bit_of(21));
    wr(6, 32'h100000); settle(3);
    chk("R9 err_req after clear", err_req, 0);
    // R6: arming ch21 drives low group
    wr(0, 32'h200000); settle(3);
    chk("R6 irq_low from ch21", irq_low, 1);
    wr(6, 32'h200000); settle(3);
    chk("R6 irq_low after clear", irq_low, 0);
    set_ev('0);
    wr(1, '1); wr(5, '1); settle(3);

    // R7 sweep: every channel against a second one in the high group
    for (int b = 0; b < NB; b++) begin wr(b*8, '1); wr(b*8 + 2, '1); end
    for (int c = 0; c < N; c++) begin
      int p;
      int lo;
      p = (c * 37 + 11) % N;
      lo = (p < c) ? p : c;
      clear_status();
      set_ev(bit_of(c) | bit_of(p)); settle(6);
      rd(A_OFF_HI, d); chk("R7 sweep high offset", d, DW'(lo + 1));
      rd(A_OFF_LO, d); chk("R7 sweep low offset", d, 0);
      chk("R6 sweep irq_high", irq_high, 1);
      set_ev('0); settle(3);
    end

    // R4/R7 sweep: even channels high, odd channels low
    for (int b = 0; b < NB; b++) begin wr(b*8 + 3, '1); wr(b*8 + 2, 32'h55555555); end
    for (int c = 0; c < N - 1; c++) begin
      int ev_ch;
      int od_ch;
      ev_ch = (c % 2 == 0) ? c : c + 1;
      od_ch = (c % 2 == 0) ? c + 1 : c;
      clear_status();
      set_ev(bit_of(c) | bit_of(c + 1)); settle(6);
      rd(A_OFF_HI, d); chk("R4 split high offset", d, DW'(ev_ch + 1));
      rd(A_OFF_LO, d); chk("R4 split low offset", d, DW'(od_ch + 1));
      set_ev('0); settle(3);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule